// File: doc/BRIEF.md
# Tap-Selectable Programmable Timer

This block is a digital interval timer. A 16-bit binary counter advances once for each clock cycle in which the `tick` enable is high. Two select inputs pick one of four counter stages. The selected stage is the timer output, and it can be presented true or inverted. The `tick` enable stands in for an oscillator, so the block's time base is whatever rate drives it.

In divider mode (`mode` high), the output is a square wave. Its period is 2^N ticks, where N is the stage number. In one-shot mode (`mode` low), the output rises once 2^(N-1) ticks have passed since master reset was released. A separate latch then keeps the output high through later counter wraps. The latch clears on master reset or when divider mode is chosen.

A control state machine governs when counting is allowed. It has three states:
- `ST_RUN`: counting is allowed.
- `ST_HOLD`: counting is frozen at zero.
- `ST_ARMED`: master reset is high after a hold, and the timer is waiting for it to fall.

The synchronous reset `rst` stands in for power-on reset and leads to one of two states:
- With `auto_dis` low, reset lands in `ST_RUN`, so timing starts at once from a cleared state.
- With `auto_dis` high, reset lands in `ST_HOLD`.

The named transitions are:
- HOLD→ARMED when `mreset` rises.
- ARMED→RUN when `mreset` falls.
- ARMED stays ARMED while `mreset` is high.
- RUN stays RUN.

Top module: `tap_timer`

## Requirements
- R1: When `rst` is sampled high with `auto_dis` low, the counter and latch clear, and counting begins on the next `tick` without any master reset. `tmr_out` equals `invert` right after reset.
- R2: When `rst` is sampled high with `auto_dis` high, the timer enters `ST_HOLD`, where ticks leave the counter at zero. Counting begins only once a `mreset` high pulse has been applied and has returned low.
- R3: In a counting state with `mreset` low, each cycle with `tick` high adds one to the 16-bit counter, wrapping from 65535 to 0.
- R4: The tap is chosen by {`sel_b`,`sel_a`}: 00 selects stage 13, 01 selects stage 10, 10 selects stage 8 and 11 selects stage 16. Stage k is counter bit k-1.
- R5: With `mode` = 1 and `invert` = 0, `tmr_out` equals the selected stage. It is therefore low for the first 2^(N-1) ticks after a clear and high for the next 2^(N-1) ticks.
- R6: With `mode` = 0 and `invert` = 0, `tmr_out` goes high when the 2^(N-1)-th tick after a clear lands. It then stays high through further counts and wraps.
- R7: The one-shot latch is cleared by `mreset` high or by `mode` = 1. After either, one-shot output follows the stage again until it re-latches.
- R8: `invert` = 1 inverts `tmr_out` in both modes.
- R9: While `mreset` is high, the counter is zero and ticks are ignored. Counting resumes in the first cycle `mreset` is low.
- R10: When `mreset` and `tick` are high in the same cycle, the clear wins and the counter is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick | input | 1 | Count enable, one count per high cycle |
| mreset | input | 1 | Master reset, active high, synchronous |
| auto_dis | input | 1 | High: reset enters hold until a master reset pulse |
| sel_a | input | 1 | Tap select, low bit |
| sel_b | input | 1 | Tap select, high bit |
| mode | input | 1 | 1: square-wave divider, 0: latched one-shot |
| invert | input | 1 | 1: output inverted |
| tmr_out | output | 1 | Timer output |

## Verification
Two operations can land on the same edge, and both are provoked deliberately.

The first is master reset arriving in the same cycle as a count tick. The bench brings the counter to one tick short of the stage-8 threshold, then raises `mreset` and `tick` together. It judges the result by how many further ticks the output needs to rise: exactly 128 if the clear won, fewer if the tick slipped through.

The second is master reset meeting the one-shot latch as it is about to set. The same coincidence is repeated in one-shot mode, and the output must stay low afterwards rather than latch.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tt_state_e;

    localparam int TT_NUM_TAPS = 4;
    localparam int TT_SEL_W    = $clog2(TT_NUM_TAPS);

endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl
    import tt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      auto_dis,
    input  logic      mreset,
    input  logic      tick,
    output tt_state_e state_q,
    output logic      cnt_clr,
    output logic      cnt_inc
);

    tt_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= auto_dis ? ST_HOLD : ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (mreset)  state_d = ST_ARMED;
            ST_ARMED: if (!mreset) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        cnt_clr = mreset;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_HOLD:  cnt_inc = 1'b0;
            ST_ARMED: cnt_inc = tick && !mreset;
            ST_RUN:   cnt_inc = tick && !mreset;
            default:  cnt_inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tt_tap_sel.sv
module tt_tap_sel
    import tt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STG_00 = 13,
    parameter int STG_01 = 10,
    parameter int STG_10 = 8,
    parameter int STG_11 = 16
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic [TT_SEL_W-1:0] sel,
    output logic                tap
);

    localparam int STG [TT_NUM_TAPS] = '{STG_00, STG_01, STG_10, STG_11};

    logic [CNT_W-1:0] masks [TT_NUM_TAPS];

    for (genvar i = 0; i < TT_NUM_TAPS; i++) begin : g_mask
        if (STG[i] < 1 || STG[i] > CNT_W) begin : g_bad
            $error("tap stage out of counter range");
        end
        assign masks[i] = {{(CNT_W-1){1'b0}}, 1'b1} << (STG[i] - 1);
    end

    assign tap = |(cnt & masks[sel]);

endmodule

// File: rtl/tt_oneshot.sv
module tt_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic mreset,
    input  logic mode,
    input  logic invert,
    input  logic tap,
    output logic latch_q,
    output logic out
);

    always_ff @(posedge clk) begin
        if (rst || mreset || mode) begin
            latch_q <= 1'b0;
        end else if (tap) begin
            latch_q <= 1'b1;
        end
    end

    logic level;
    assign level = mode ? tap : (tap | latch_q);
    assign out   = level ^ invert;

endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STG_00 = 13,
    parameter int STG_01 = 10,
    parameter int STG_10 = 8,
    parameter int STG_11 = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mreset,
    input  logic auto_dis,
    input  logic sel_a,
    input  logic sel_b,
    input  logic mode,
    input  logic invert,
    output logic tmr_out
);

    tt_state_e        state_q;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] count_q;
    logic             tap;
    logic             latch_q;

    tt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .auto_dis (auto_dis),
        .mreset   (mreset),
        .tick     (tick),
        .state_q  (state_q),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .count_q (count_q)
    );

    tt_tap_sel #(
        .CNT_W  (CNT_W),
        .STG_00 (STG_00),
        .STG_01 (STG_01),
        .STG_10 (STG_10),
        .STG_11 (STG_11)
    ) u_tap (
        .cnt (count_q),
        .sel ({sel_b, sel_a}),
        .tap (tap)
    );

    tt_oneshot u_shot (
        .clk     (clk),
        .rst     (rst),
        .mreset  (mreset),
        .mode    (mode),
        .invert  (invert),
        .tap     (tap),
        .latch_q (latch_q),
        .out     (tmr_out)
    );

endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk
    import tt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             mreset,
    input logic             auto_dis,
    input logic             sel_a,
    input logic             sel_b,
    input logic             mode,
    input logic             invert,
    input logic             tmr_out,
    input tt_state_e        state_q,
    input logic [CNT_W-1:0] count_q,
    input logic             latch_q
);

    p_auto_start_r1: assert property (@(posedge clk)
        (rst && !auto_dis) |=> (state_q == ST_RUN && count_q == '0 && !latch_q));

    p_hold_entry_r2: assert property (@(posedge clk)
        (rst && auto_dis) |=> (state_q == ST_HOLD && count_q == '0));

    p_hold_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> (count_q == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !mreset && state_q != ST_HOLD)
        |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    p_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !mreset) ##1 ($stable({sel_a, sel_b, mode, invert}))
        |-> $stable(tmr_out));

    p_latch_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !mode && !mreset) |=> latch_q);

    p_latched_high_r6: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !mode && !invert) |-> tmr_out);

    p_latch_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (mode || mreset) |=> !latch_q);

    p_mreset_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (mreset && tick) |=> (count_q == '0));

endmodule

bind tap_timer tap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mreset   (mreset),
    .auto_dis (auto_dis),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .mode     (mode),
    .invert   (invert),
    .tmr_out  (tmr_out),
    .state_q  (state_q),
    .count_q  (count_q),
    .latch_q  (latch_q)
);

// File: tb/tap_timer_tb.sv
module tap_timer_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic mreset = 1'b0;
    logic auto_dis = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b1;
    logic mode = 1'b1;
    logic invert = 1'b0;
    logic tmr_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tap_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mreset   (mreset),
        .auto_dis (auto_dis),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .mode     (mode),
        .invert   (invert),
        .tmr_out  (tmr_out)
    );

    // vector fields: {sel_b, sel_a, mode, invert, ticks[16:0], expected}
    localparam int NV = 14;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 1'b0, 17'd127,   1'b0},
        {1'b1, 1'b0, 1'b1, 1'b0, 17'd128,   1'b1},
        {1'b1, 1'b0, 1'b1, 1'b0, 17'd256,   1'b0},
        {1'b0, 1'b1, 1'b1, 1'b0, 17'd511,   1'b0},
        {1'b0, 1'b1, 1'b1, 1'b0, 17'd512,   1'b1},
        {1'b0, 1'b0, 1'b1, 1'b0, 17'd4095,  1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 17'd4096,  1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 17'd32767, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 17'd32768, 1'b1},
        {1'b1, 1'b0, 1'b0, 1'b0, 17'd127,   1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 17'd128,   1'b1},
        {1'b1, 1'b0, 1'b0, 1'b0, 17'd300,   1'b1},
        {1'b1, 1'b0, 1'b1, 1'b1, 17'd128,   1'b0},
        {1'b1, 1'b0, 1'b0, 1'b1, 17'd300,   1'b0}
    };

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) cycle();
        tick = 1'b0;
    endtask

    task automatic mr_pulse();
        mreset = 1'b1;
        tick   = 1'b0;
        cycle();
        mreset = 1'b0;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tmr_out got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: cycles got %0d expected below 190000", cycles);
                finish_run();
            end
        end
    end

    initial begin : stim
        // R1: auto reset enabled, reset state and free start
        rst = 1'b1; auto_dis = 1'b0;
        cycle(); cycle();
        rst = 1'b0;
        check("R1 reset output low", tmr_out, 1'b0);
        invert = 1'b1; cycle();
        check("R8 reset output inverted", tmr_out, 1'b1);
        invert = 1'b0;
        run_ticks(128);
        check("R1 counts without master reset", tmr_out, 1'b1);

        // R2: auto reset disabled, hold until master reset pulse ends
        rst = 1'b1; auto_dis = 1'b1;
        cycle();
        rst = 1'b0;
        run_ticks(200);
        check("R2 ticks ignored in hold", tmr_out, 1'b0);
        mr_pulse();
        run_ticks(128);
        check("R2 counting after pulse", tmr_out, 1'b1);

        // vector table: R4 selects, R5 divider, R6 one-shot, R8 invert
        for (int v = 0; v < NV; v++) begin
            sel_b  = VEC[v][21];
            sel_a  = VEC[v][20];
            mode   = VEC[v][19];
            invert = VEC[v][18];
            mr_pulse();
            run_ticks(int'(VEC[v][17:1]));
            if (VEC[v][18])
                check($sformatf("R8 vector %0d", v), tmr_out, VEC[v][0]);
            else if (VEC[v][19])
                check($sformatf("R4/R5 vector %0d", v), tmr_out, VEC[v][0]);
            else
                check($sformatf("R6 vector %0d", v), tmr_out, VEC[v][0]);
        end

        // R3: counter wraps at the stage-8 period and keeps going
        sel_b = 1'b1; sel_a = 1'b0; mode = 1'b1; invert = 1'b0;
        mr_pulse();
        run_ticks(256 + 128);
        check("R3 count continues after stage wrap", tmr_out, 1'b1);

        // R7: leaving one-shot mode clears the latch
        mode = 1'b0;
        mr_pulse();
        run_ticks(300);
        check("R7 latched before mode change", tmr_out, 1'b1);
        mode = 1'b1; cycle();
        check("R7 divider shows stage", tmr_out, 1'b0);
        mode = 1'b0; cycle();
        check("R7 latch cleared by mode", tmr_out, 1'b0);
        run_ticks(212);
        check("R7 re-latched", tmr_out, 1'b1);
        mreset = 1'b1; cycle();
        check("R7 latch cleared by master reset", tmr_out, 1'b0);
        mreset = 1'b0;

        // R9: master reset held with ticks
        mode = 1'b1;
        mreset = 1'b1; tick = 1'b1;
        for (int i = 0; i < 200; i++) cycle();
        check("R9 ticks ignored under master reset", tmr_out, 1'b0);
        mreset = 1'b0;
        run_ticks(127);
        check("R9 resume count 127", tmr_out, 1'b0);
        run_ticks(1);
        check("R9 resume count 128", tmr_out, 1'b1);

        // R10: master reset and tick in the same cycle, divider mode
        mr_pulse();
        run_ticks(127);
        mreset = 1'b1; tick = 1'b1; cycle();
        mreset = 1'b0; tick = 1'b0;
        run_ticks(127);
        check("R10 clear wins over tick (127)", tmr_out, 1'b0);
        run_ticks(1);
        check("R10 clear wins over tick (128)", tmr_out, 1'b1);

        // R10: coincidence in one-shot mode must not latch
        mode = 1'b0;
        mr_pulse();
        run_ticks(127);
        mreset = 1'b1; tick = 1'b1; cycle();
        mreset = 1'b0; tick = 1'b0;
        check("R10 one-shot clear wins", tmr_out, 1'b0);
        cycle();
        check("R10 one-shot not latched", tmr_out, 1'b0);

        finish_run();
    end

endmodule